// File: doc/BRIEF.md
# Wakeup Event Line Controller

This block collects single-bit status signals from the power and timekeeping parts of a chip and turns their transitions into interrupt requests and a wakeup pulse for the power controller. Each line can be armed for rising transitions, falling transitions or both. Each line also has its own interrupt enable and event enable, so a transition can raise an interrupt, a wake event, both or neither.

A small write/read register port holds the configuration. Software can write whole enable vectors at once, or reconfigure one line with a single command. That command replaces all four controls of the chosen line and leaves every other line alone. A qualifying transition on a line whose interrupt enable is set latches a sticky pending bit. Software clears the bit by writing one to it. The interrupt vector shows pending bits gated by their enables. Any qualifying transition on a line whose event enable is set produces a one-cycle pulse on the shared wake output.

Six lines have fixed sources: the supply-voltage detector, the clock alarm, tamper/timestamp, the periodic clock wakeup and two comparators. The remaining lines come from a general-purpose input vector.

Top module: `wkc_top`

## Requirements
- R1: After reset, all enable vectors and the pending vector read zero, `irq_o` is zero and `wake_evt_o` is low.
- R2: On a line with the rising enable set and the falling enable clear, a 0-to-1 source change sets the pending bit, and a 1-to-0 change does nothing. Latency: the source change is first captured at clock edge k, and the pending bit reads one after edge k+2. Read address 4 returns the pending vector.
- R3: On a line with only the falling enable set, a 1-to-0 change sets the pending bit and a 0-to-1 change does not.
- R4: With both the rising and falling enables set, each transition direction sets the pending bit.
- R5: A line with neither trigger enable set never sets its pending bit and never pulses `wake_evt_o`, whatever its other enables are.
- R6: `irq_o[i]` is one exactly when pending bit i and interrupt enable i are both one. Clearing the enable hides the request but keeps the pending bit.
- R7: A qualifying transition pulses `wake_evt_o` for exactly one cycle, in the same cycle the pending bit would set, only if the line's event enable is set. A transition on a line whose interrupt enable is clear leaves its pending bit clear.
- R8: A write to address 4 clears each pending bit whose data bit is one. Zero data bits leave their pending bits unchanged, and pending bits stay set until cleared this way.
- R9: If a qualifying transition and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R10: A write to address 5 reconfigures one line. Data bits [4:0] carry the line index, bit 5 is the interrupt enable, bit 6 the event enable, bit 7 the rising enable and bit 8 the falling enable. All four controls of that line take the written values, and no other line changes.
- R11: Line 16 takes the voltage-detector input, 17 the alarm, 19 tamper/timestamp, 20 the periodic wakeup, and 21 and 22 the two comparators. Bits of `gp_lines_i` at those positions are ignored, and every other line follows its `gp_lines_i` bit.
- R12: The enable vectors are written and read whole: address 0 holds the rising enables, 1 the falling enables, 2 the interrupt enables and 3 the event enables. A read of `rd_addr_i` returns the vector in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdet_i | input | 1 | Supply-voltage detector output (line 16) |
| rtc_alarm_i | input | 1 | Clock alarm (line 17) |
| rtc_tamp_i | input | 1 | Tamper / timestamp (line 19) |
| rtc_wkup_i | input | 1 | Periodic clock wakeup (line 20) |
| cmp1_i | input | 1 | Comparator 1 output (line 21) |
| cmp2_i | input | 1 | Comparator 2 output (line 22) |
| gp_lines_i | input | NLINES | General-purpose line sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | NLINES | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | NLINES | Register read data |
| irq_o | output | NLINES | Per-line interrupt requests |
| wake_evt_o | output | 1 | Combined one-cycle wake event pulse |

## Verification
Each fixed source is driven through rising-only, falling-only, both-edge and untriggered setups. Comparing the pending vector after each direction of change shows whether the edge qualifier tells the two directions apart. Event-only and interrupt-only lines separate the two output paths: a wake pulse with no pending bit, or a pending bit with no pulse, shows which path is at fault. A clear write is placed in the exact cycle a falling edge qualifies, to settle the priority between the two. A general-purpose bit is toggled at a fixed-source position to confirm that the fixed source owns that line.

// File: rtl/wkc_pkg.sv
package wkc_pkg;

    // Fixed source positions; the power controller decodes these line numbers.
    localparam int unsigned LN_VDET  = 16;
    localparam int unsigned LN_ALARM = 17;
    localparam int unsigned LN_TAMP  = 19;
    localparam int unsigned LN_RTCWK = 20;
    localparam int unsigned LN_CMP1  = 21;
    localparam int unsigned LN_CMP2  = 22;
    localparam int unsigned MIN_LINES = 23;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_RISE = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_FALL = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_IMSK = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_EMSK = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_PEND = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_LCFG = 3'd5;

    // Mode bit offsets above the line index in a line-configure write.
    localparam int unsigned LC_IRQ  = 0;
    localparam int unsigned LC_EVT  = 1;
    localparam int unsigned LC_RISE = 2;
    localparam int unsigned LC_FALL = 3;

endpackage

// File: rtl/wkc_sync.sv
module wkc_sync #(
    parameter int unsigned W = 23
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stab;

endmodule

// File: rtl/wkc_edge.sv
module wkc_edge #(
    parameter int unsigned W = 23
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/wkc_cfg.sv
module wkc_cfg
    import wkc_pkg::*;
#(
    parameter int unsigned N = 23
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [N-1:0]      wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [N-1:0]      rd_data_o,
    input  logic [N-1:0]      rise_pls_i,
    input  logic [N-1:0]      fall_pls_i,
    output logic [N-1:0]      rise_en_o,
    output logic [N-1:0]      fall_en_o,
    output logic [N-1:0]      irq_en_o,
    output logic [N-1:0]      evt_en_o,
    output logic [N-1:0]      pend_o,
    output logic              evt_o
);

    localparam int unsigned LIDX_W = $clog2(N);
    localparam int unsigned MODE_B = LIDX_W;

    typedef struct packed {
        logic [N-1:0] rise;
        logic [N-1:0] fall;
        logic [N-1:0] imsk;
        logic [N-1:0] emsk;
        logic [N-1:0] pend;
        logic         evt;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    logic [N-1:0]        trig;
    logic [N-1:0]        clr;
    logic [LIDX_W-1:0]   sel;

    always_comb begin
        st_d = st_q;
        sel  = wr_data_i[LIDX_W-1:0];
        trig = (rise_pls_i & st_q.rise) | (fall_pls_i & st_q.fall);
        clr  = '0;

        if (wr_en_i) begin
            case (wr_addr_i)
                ADR_RISE: st_d.rise = wr_data_i;
                ADR_FALL: st_d.fall = wr_data_i;
                ADR_IMSK: st_d.imsk = wr_data_i;
                ADR_EMSK: st_d.emsk = wr_data_i;
                ADR_PEND: clr = wr_data_i;
                ADR_LCFG: begin
                    for (int l = 0; l < N; l++) begin
                        if (sel == LIDX_W'(l)) begin
                            st_d.imsk[l] = wr_data_i[MODE_B + LC_IRQ];
                            st_d.emsk[l] = wr_data_i[MODE_B + LC_EVT];
                            st_d.rise[l] = wr_data_i[MODE_B + LC_RISE];
                            st_d.fall[l] = wr_data_i[MODE_B + LC_FALL];
                        end
                    end
                end
                default: ;
            endcase
        end

        // New qualifying edges override a simultaneous clear.
        st_d.pend = (st_q.pend & ~clr) | (trig & st_q.imsk);
        st_d.evt  = |(trig & st_q.emsk);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_addr_i)
            ADR_RISE: rd_data_o = st_q.rise;
            ADR_FALL: rd_data_o = st_q.fall;
            ADR_IMSK: rd_data_o = st_q.imsk;
            ADR_EMSK: rd_data_o = st_q.emsk;
            ADR_PEND: rd_data_o = st_q.pend;
            default:  rd_data_o = '0;
        endcase
    end

    assign rise_en_o = st_q.rise;
    assign fall_en_o = st_q.fall;
    assign irq_en_o  = st_q.imsk;
    assign evt_en_o  = st_q.emsk;
    assign pend_o    = st_q.pend;
    assign evt_o     = st_q.evt;

endmodule

// File: rtl/wkc_top.sv
module wkc_top
    import wkc_pkg::*;
#(
    parameter int unsigned NLINES = 23
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              vdet_i,
    input  logic              rtc_alarm_i,
    input  logic              rtc_tamp_i,
    input  logic              rtc_wkup_i,
    input  logic              cmp1_i,
    input  logic              cmp2_i,
    input  logic [NLINES-1:0] gp_lines_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [NLINES-1:0] wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [NLINES-1:0] rd_data_o,
    output logic [NLINES-1:0] irq_o,
    output logic              wake_evt_o
);

    logic [NLINES-1:0] src;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] rise_pls;
    logic [NLINES-1:0] fall_pls;
    logic [NLINES-1:0] rise_en;
    logic [NLINES-1:0] fall_en;
    logic [NLINES-1:0] irq_en;
    logic [NLINES-1:0] evt_en;
    logic [NLINES-1:0] pend;

    // Fixed sources own their lines; the general-purpose bits there are dropped.
    always_comb begin
        src           = gp_lines_i;
        src[LN_VDET]  = vdet_i;
        src[LN_ALARM] = rtc_alarm_i;
        src[LN_TAMP]  = rtc_tamp_i;
        src[LN_RTCWK] = rtc_wkup_i;
        src[LN_CMP1]  = cmp1_i;
        src[LN_CMP2]  = cmp2_i;
    end

    wkc_sync #(.W(NLINES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src),
        .sync_o  (lvl)
    );

    wkc_edge #(.W(NLINES)) edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl),
        .rise_o (rise_pls),
        .fall_o (fall_pls)
    );

    wkc_cfg #(.N(NLINES)) cfg_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .rise_pls_i (rise_pls),
        .fall_pls_i (fall_pls),
        .rise_en_o  (rise_en),
        .fall_en_o  (fall_en),
        .irq_en_o   (irq_en),
        .evt_en_o   (evt_en),
        .pend_o     (pend),
        .evt_o      (wake_evt_o)
    );

    assign irq_o = pend & irq_en;

endmodule

// File: rtl/wkc_chk.sv
module wkc_chk #(
    parameter int unsigned N = 23
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         wr_en_i,
    input logic [2:0]   wr_addr_i,
    input logic [N-1:0] wr_data_i,
    input logic [N-1:0] rise_en_i,
    input logic [N-1:0] fall_en_i,
    input logic [N-1:0] irq_en_i,
    input logic [N-1:0] evt_en_i,
    input logic [N-1:0] pend_i,
    input logic [N-1:0] irq_i,
    input logic         wake_i
);

    assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (pend_i == '0 && !wake_i));

    assert_evt_needs_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |-> $past(|evt_en_i));

    for (genvar g = 0; g < N; g++) begin : g_line
        assert_pend_needs_ie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(pend_i[g]) |-> $past(irq_en_i[g]));

        assert_pend_needs_trig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(pend_i[g]) |-> $past(rise_en_i[g] | fall_en_i[g]));

        assert_pend_fall_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(pend_i[g]) |-> $past(wr_en_i && wr_addr_i == 3'd4 && wr_data_i[g]));

        assert_irq_needs_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_i[g] |-> pend_i[g]);
    end

endmodule

bind wkc_top wkc_chk #(.N(NLINES)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .irq_en_i  (irq_en),
    .evt_en_i  (evt_en),
    .pend_i    (pend),
    .irq_i     (irq_o),
    .wake_i    (wake_evt_o)
);

// File: tb/wkc_top_tb_top.sv
`timescale 1ns/1ps
module wkc_top_tb_top;

    localparam int N = 23;
    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_EVT = 2;

    typedef struct {
        int           at;
        int           kind;
        string        req;
        logic [N-1:0] val;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vdet = 1'b0, alarm = 1'b0, tamp = 1'b0, rwk = 1'b0, c1 = 1'b0, c2 = 1'b0;
    logic [N-1:0] gp = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_addr = 3'd4;
    logic [N-1:0] rd_data;
    logic [N-1:0] irq;
    logic         wake;

    logic [N-1:0] m_rise = '0, m_fall = '0, m_imsk = '0, m_emsk = '0;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    item_t sq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wkc_top #(.NLINES(N)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .vdet_i      (vdet),
        .rtc_alarm_i (alarm),
        .rtc_tamp_i  (tamp),
        .rtc_wkup_i  (rwk),
        .cmp1_i      (c1),
        .cmp2_i      (c2),
        .gp_lines_i  (gp),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .irq_o       (irq),
        .wake_evt_o  (wake)
    );

    // Monitor: pops expected items as their cycle comes due.
    always @(negedge clk) begin : mon
        item_t        it;
        logic [N-1:0] act;
        while (sq.size() > 0 && sq[0].at <= cyc) begin
            it = sq.pop_front();
            case (it.kind)
                K_RD:    act = rd_data;
                K_IRQ:   act = irq;
                default: act = {{(N-1){1'b0}}, wake};
            endcase
            total++;
            if (it.at != cyc || act !== it.val) begin
                bad++;
                $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                         it.req, it.kind, cyc, act, it.val);
            end
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic push(int kind, int dt, string req, logic [N-1:0] val);
        item_t it;
        it.at = cyc + dt;
        it.kind = kind;
        it.req = req;
        it.val = val;
        sq.push_back(it);
    endtask

    function automatic logic [N-1:0] bitv(int l);
        return N'(1) << l;
    endfunction

    task automatic wr(logic [2:0] a, logic [N-1:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en = 1'b0;
        case (a)
            3'd0: m_rise = d;
            3'd1: m_fall = d;
            3'd2: m_imsk = d;
            3'd3: m_emsk = d;
            default: ;
        endcase
    endtask

    // R10 encoding: [4:0] line, 5 irq, 6 evt, 7 rise, 8 fall.
    task automatic lcfg(int l, bit ie, bit ee, bit re, bit fe);
        logic [N-1:0] d;
        d = '0;
        d[4:0] = 5'(l);
        d[5] = ie;
        d[6] = ee;
        d[7] = re;
        d[8] = fe;
        wr(3'd5, d);
        m_imsk[l] = ie;
        m_emsk[l] = ee;
        m_rise[l] = re;
        m_fall[l] = fe;
    endtask

    task automatic readback(logic [2:0] a, logic [N-1:0] exp, string req);
        rd_addr = a;
        push(K_RD, 0, req, exp);
        step();
        rd_addr = 3'd4;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog cyc=%0d actual=hung expected=finished", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] keep;
        step(4);
        rst_n = 1'b1;
        // R1: reset state
        push(K_RD, 1, "R1", '0);
        push(K_IRQ, 1, "R1", '0);
        push(K_EVT, 1, "R1", '0);
        step(2);
        readback(3'd0, '0, "R1");
        readback(3'd2, '0, "R1");

        // R2 / R7: alarm line, rising only, irq and event enabled
        lcfg(17, 1, 1, 1, 0);
        alarm = 1'b1;
        push(K_RD, 3, "R2", bitv(17));
        push(K_IRQ, 3, "R6", bitv(17));
        push(K_EVT, 3, "R7", 1);
        push(K_EVT, 4, "R7", 0);
        step(6);
        alarm = 1'b0;
        push(K_RD, 3, "R2", bitv(17));
        push(K_EVT, 3, "R2", 0);
        step(6);

        // R8: write-one-to-clear
        wr(3'd4, '0);
        push(K_RD, 0, "R8", bitv(17));
        wr(3'd4, bitv(17));
        push(K_RD, 0, "R8", '0);
        push(K_IRQ, 0, "R8", '0);
        step(2);

        // R3: detector line, falling only
        lcfg(16, 1, 0, 0, 1);
        vdet = 1'b1;
        push(K_RD, 3, "R3", '0);
        step(5);
        vdet = 1'b0;
        push(K_RD, 3, "R3", bitv(16));
        push(K_IRQ, 3, "R3", bitv(16));
        step(5);
        wr(3'd4, bitv(16));
        step(2);

        // R4: periodic wakeup line, both edges
        lcfg(20, 1, 0, 1, 1);
        rwk = 1'b1;
        push(K_RD, 3, "R4", bitv(20));
        step(5);
        wr(3'd4, bitv(20));
        step();
        rwk = 1'b0;
        push(K_RD, 3, "R4", bitv(20));
        step(5);
        wr(3'd4, bitv(20));
        step(2);

        // R5: comparator 1 with no trigger enables
        lcfg(21, 1, 1, 0, 0);
        c1 = 1'b1;
        push(K_EVT, 3, "R5", 0);
        push(K_RD, 3, "R5", '0);
        push(K_EVT, 4, "R5", 0);
        step(5);
        c1 = 1'b0;
        step(5);

        // R7: comparator 2, event only
        lcfg(22, 0, 1, 1, 0);
        c2 = 1'b1;
        push(K_EVT, 3, "R7", 1);
        push(K_RD, 3, "R7", '0);
        push(K_EVT, 4, "R7", 0);
        step(6);
        c2 = 1'b0;
        step(3);

        // R6: masking hides the request, pending stays
        lcfg(19, 1, 0, 1, 0);
        tamp = 1'b1;
        push(K_RD, 3, "R6", bitv(19));
        push(K_IRQ, 3, "R6", bitv(19));
        step(5);
        wr(3'd2, m_imsk & ~bitv(19));
        push(K_IRQ, 0, "R6", '0);
        push(K_RD, 0, "R6", bitv(19));
        step();
        wr(3'd2, m_imsk | bitv(19));
        push(K_IRQ, 0, "R6", bitv(19));
        step();
        wr(3'd4, bitv(19));
        step(2);

        // R9: clear and edge in the same cycle
        lcfg(19, 1, 0, 1, 1);
        tamp = 1'b0;
        step(2);
        wr_en = 1'b1;
        wr_addr = 3'd4;
        wr_data = bitv(19);
        push(K_RD, 1, "R9", bitv(19));
        step();
        wr_en = 1'b0;
        step(3);
        wr(3'd4, bitv(19));
        push(K_RD, 0, "R8", '0);
        step(2);

        // R10: single-line reconfigure
        lcfg(17, 0, 0, 0, 1);
        readback(3'd0, m_rise, "R10");
        readback(3'd1, m_fall, "R10");
        readback(3'd2, m_imsk, "R10");
        readback(3'd3, m_emsk, "R10");

        // R12: whole-vector write and read
        keep = m_rise;
        wr(3'd0, 23'h0A5A5);
        readback(3'd0, 23'h0A5A5, "R12");
        wr(3'd3, 23'h15A5A);
        readback(3'd3, 23'h15A5A, "R12");
        wr(3'd3, '0);
        wr(3'd0, keep);
        readback(3'd0, keep, "R12");

        // R11: source mapping
        lcfg(3, 1, 0, 1, 0);
        gp[3] = 1'b1;
        push(K_RD, 3, "R11", bitv(3));
        step(5);
        wr(3'd4, bitv(3));
        lcfg(16, 1, 0, 1, 0);
        gp[16] = 1'b1;
        push(K_RD, 3, "R11", '0);
        step(5);
        vdet = 1'b1;
        push(K_RD, 3, "R11", bitv(16));
        step(5);

        step(4);
        if (sq.size() != 0) begin
            bad++;
            total++;
            $display("FAIL queue actual=%0d expected=0", sq.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule